// File: doc/BRIEF.md
# Calendar and Time-of-Day Counter with Alarms

This block keeps the time and date for a real-time clock. A prescaler divides the incoming 32.768 kHz clock into one enable per second. Each enable advances seconds, minutes, hours, day of week, date, month, two-digit year and century. Carries ripple through all the fields in the same cycle, so the calendar runs from year 0000 to 9999 and then wraps. There is no daylight-saving correction. After every advance the block gives a one-cycle update strobe.

An input selects the encoding for every field, alarms included. In one setting each field holds two BCD digits. In the other it holds a plain binary value. Two alarms are checked on each update. The time-of-day alarm compares seconds, minutes and hours. The wake-up alarm also compares date, month, year and century. An alarm field whose top two bits are both set matches any value.

A host sets and reads every field through a register port. Writes are synchronous and reads are combinational.

Top module: `rtc_calendar_core`

## Requirements
- R1: While reset is held, the fields read as follows: time 00:00:00, day of week 1, date 01, month 01, year 00 and century 00. All alarm registers read 0x00, and upd_done, alarm_tod and alarm_wake are low.
- R2: The time advances once every PRESC_DIV clock cycles. Seconds run 0..59 and carry into minutes. Minutes run 0..59 and carry into hours. Hours run 0..23 and carry into the next day.
- R3: When bin_mode=0, each field is two BCD digits, so 59 is 0x59. When bin_mode=1, each field is binary, so 59 is 0x3B. Advancing and alarm matching both use the selected encoding.
- R4: Day of week counts 1..7 and steps from 7 back to 1 when the day changes.
- R5: The date wraps to 1 and carries into the month after the last day of the month. Months 4, 6, 9 and 11 have 30 days and month 2 has 28 or 29 days. All other months have 31 days. Month 12 wraps to 1 and carries into the year.
- R6: February has 29 days in a leap year. When year is 00, the year is a leap year only if the century is a multiple of 4, so 2000 is a leap year and 1900 is not. For any other year, it is a leap year when the year is a multiple of 4.
- R7: Year 99 wraps to 00 and carries into the century. Century 99 wraps to 00, so 9999 is followed by 0000.
- R8: upd_done is high for exactly one cycle, the cycle after each advance.
- R9: alarm_tod is high together with upd_done when the updated seconds, minutes and hours all match the alarm registers. An alarm field in the range 0xC0..0xFF matches any value.
- R10: alarm_wake is high together with upd_done when seconds, minutes, hours, date, month, year and century all match. The wake-up fields follow the same don't-care rule as R9.
- R11: When wr_en is high, wr_data is stored at wr_addr. rd_data shows the register at rd_addr in the same cycle. The map is:
  - 0 seconds, 1 minutes, 2 hours, 3 day of week
  - 4 date, 5 month, 6 year, 7 century
  - 8 alarm seconds, 9 alarm minutes, 10 alarm hours
  - 11 wake date, 12 wake month, 13 wake year, 14 wake century
  - 15 reads 0x00
- R12: A write in the same cycle as an advance takes effect as follows. The written field takes wr_data, the other fields take their advanced values, and upd_done still follows.
- R13: With no advance and no write, every time field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read data, combinational |
| upd_done | output | 1 | One-cycle strobe after each advance |
| alarm_tod | output | 1 | Time-of-day alarm strobe |
| alarm_wake | output | 1 | Wake-up alarm strobe |

## Verification
A host write and the one-second advance can fall in the same clock cycle. The bench locks onto upd_done and counts PRESC_DIV-1 cycles, which places a minutes write exactly on the advance edge. It then checks three things. The minutes field must hold the written value and the seconds field must still have stepped. upd_done must also appear in the next cycle. The alarm strobes share the update cycle, so they are judged at the same sample point as upd_done.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
        logic [7:0] cent;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] a_sec;
        logic [7:0] a_min;
        logic [7:0] a_hour;
        logic [7:0] w_date;
        logic [7:0] w_month;
        logic [7:0] w_year;
        logic [7:0] w_cent;
    } rtc_alarm_t;

    // Field value in its encoding -> plain binary
    function automatic logic [7:0] fld_dec(input logic [7:0] v, input logic bcd);
        logic [7:0] hi;
        hi = {4'b0, v[7:4]} * 8'd10;
        return bcd ? (hi + {4'b0, v[3:0]}) : v;
    endfunction

    // Plain binary -> field value in its encoding
    function automatic logic [7:0] fld_enc(input logic [7:0] b, input logic bcd);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = b / 8'd10;
        ones = b % 8'd10;
        return bcd ? {tens[3:0], ones[3:0]} : b;
    endfunction

    // Alarm field match with don't-care codes 0xC0..0xFF
    function automatic logic fld_ok(input logic [7:0] a, input logic [7:0] v);
        return (a[7:6] == 2'b11) || (a == v);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: one enable per DIV cycles, never two in a row
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bcd,
    output rtc_time_t nxt
);
    logic [7:0] s, m, h, w, d, mo, y, c;
    logic [7:0] dim;
    logic       leap;
    logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;

    always_comb begin
        s  = fld_dec(cur.sec,   bcd);
        m  = fld_dec(cur.min,   bcd);
        h  = fld_dec(cur.hour,  bcd);
        w  = fld_dec(cur.dow,   bcd);
        d  = fld_dec(cur.date,  bcd);
        mo = fld_dec(cur.month, bcd);
        y  = fld_dec(cur.year,  bcd);
        c  = fld_dec(cur.cent,  bcd);

        // full year = 100*c + y; 100 is a multiple of 4
        leap = (y == 8'd0) ? (c[1:0] == 2'b00) : (y[1:0] == 2'b00);

        case (mo)
            8'd2:                      dim = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   dim = 8'd30;
            default:                   dim = 8'd31;
        endcase

        c_min  = (s >= 8'd59);
        c_hour = c_min  && (m >= 8'd59);
        c_day  = c_hour && (h >= 8'd23);
        c_mon  = c_day  && (d >= dim);
        c_year = c_mon  && (mo >= 8'd12);
        c_cent = c_year && (y >= 8'd99);

        nxt = cur;
        nxt.sec = fld_enc(c_min ? 8'd0 : s + 8'd1, bcd);
        if (c_min)  nxt.min   = fld_enc(c_hour ? 8'd0 : m + 8'd1, bcd);
        if (c_hour) nxt.hour  = fld_enc(c_day  ? 8'd0 : h + 8'd1, bcd);
        if (c_day) begin
            nxt.dow  = fld_enc((w >= 8'd7) ? 8'd1 : w + 8'd1, bcd);
            nxt.date = fld_enc(c_mon ? 8'd1 : d + 8'd1, bcd);
        end
        if (c_mon)  nxt.month = fld_enc(c_year ? 8'd1 : mo + 8'd1, bcd);
        if (c_year) nxt.year  = fld_enc(c_cent ? 8'd0 : y + 8'd1, bcd);
        if (c_cent) nxt.cent  = fld_enc((c >= 8'd99) ? 8'd0 : c + 8'd1, bcd);
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  rtc_time_t  tm,
    input  rtc_alarm_t al,
    output logic       tod_hit,
    output logic       wake_hit
);
    logic tod_part;

    always_comb begin
        tod_part = fld_ok(al.a_sec,  tm.sec)  &&
                   fld_ok(al.a_min,  tm.min)  &&
                   fld_ok(al.a_hour, tm.hour);
        tod_hit  = tod_part;
        wake_hit = tod_part                     &&
                   fld_ok(al.w_date,  tm.date)  &&
                   fld_ok(al.w_month, tm.month) &&
                   fld_ok(al.w_year,  tm.year)  &&
                   fld_ok(al.w_cent,  tm.cent);
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int PRESC_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bin_mode,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       upd_done,
    output logic       alarm_tod,
    output logic       alarm_wake
);
    typedef struct packed {
        rtc_time_t  tm;
        rtc_alarm_t al;
        logic       upd;
    } core_state_t;

    core_state_t st_d, st_q;
    rtc_time_t   tm_adv;
    logic        tick, bcd, tod_hit, wake_hit;

    assign bcd = ~bin_mode;

    rtc_prescaler #(.DIV(PRESC_DIV)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_advance i_adv (
        .cur (st_q.tm),
        .bcd (bcd),
        .nxt (tm_adv)
    );

    rtc_alarm_match i_match (
        .tm       (st_q.tm),
        .al       (st_q.al),
        .tod_hit  (tod_hit),
        .wake_hit (wake_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = tick;
        if (tick) st_d.tm = tm_adv;
        if (wr_en) begin
            case (wr_addr)
                4'd0:  st_d.tm.sec    = wr_data;
                4'd1:  st_d.tm.min    = wr_data;
                4'd2:  st_d.tm.hour   = wr_data;
                4'd3:  st_d.tm.dow    = wr_data;
                4'd4:  st_d.tm.date   = wr_data;
                4'd5:  st_d.tm.month  = wr_data;
                4'd6:  st_d.tm.year   = wr_data;
                4'd7:  st_d.tm.cent   = wr_data;
                4'd8:  st_d.al.a_sec  = wr_data;
                4'd9:  st_d.al.a_min  = wr_data;
                4'd10: st_d.al.a_hour = wr_data;
                4'd11: st_d.al.w_date = wr_data;
                4'd12: st_d.al.w_month = wr_data;
                4'd13: st_d.al.w_year = wr_data;
                4'd14: st_d.al.w_cent = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.tm.dow   <= 8'h01;
            st_q.tm.date  <= 8'h01;
            st_q.tm.month <= 8'h01;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            4'd0:    rd_data = st_q.tm.sec;
            4'd1:    rd_data = st_q.tm.min;
            4'd2:    rd_data = st_q.tm.hour;
            4'd3:    rd_data = st_q.tm.dow;
            4'd4:    rd_data = st_q.tm.date;
            4'd5:    rd_data = st_q.tm.month;
            4'd6:    rd_data = st_q.tm.year;
            4'd7:    rd_data = st_q.tm.cent;
            4'd8:    rd_data = st_q.al.a_sec;
            4'd9:    rd_data = st_q.al.a_min;
            4'd10:   rd_data = st_q.al.a_hour;
            4'd11:   rd_data = st_q.al.w_date;
            4'd12:   rd_data = st_q.al.w_month;
            4'd13:   rd_data = st_q.al.w_year;
            4'd14:   rd_data = st_q.al.w_cent;
            default: rd_data = 8'h00;
        endcase
    end

    assign upd_done   = st_q.upd;
    assign alarm_tod  = st_q.upd & tod_hit;
    assign alarm_wake = st_q.upd & wake_hit;

    // R8: update strobe lasts one cycle
    p_upd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    // R13: fields hold without an advance or a write
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(st_q.tm));

    // R2: seconds at 59 wrap to 00 on an advance
    p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && fld_dec(st_q.tm.sec, bcd) == 8'd59)
        |=> (st_q.tm.sec == 8'h00));

    // R4: day of week stays inside 1..7 across an advance
    p_dow_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.tm.dow >= 8'd1 && st_q.tm.dow <= 8'd7)
        |=> (st_q.tm.dow >= 8'd1 && st_q.tm.dow <= 8'd7));

    // R11: a seconds write is stored
    p_wr_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd0) |=> (st_q.tm.sec == $past(wr_data)));

endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/100ps
module test_rtc_calendar_core;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bin_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       upd_done, alarm_tod, alarm_wake;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rtc_calendar_core #(.PRESC_DIV(DIV)) i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .upd_done(upd_done), .alarm_tod(alarm_tod), .alarm_wake(alarm_wake)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        @(negedge clk);
    endtask

    task automatic wait_upd();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!upd_done && n < 4 * DIV);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y, c);
        wait_upd();
        wr(0, s); wr(1, m); wr(2, h); wr(3, w);
        wr(4, d); wr(5, mo); wr(6, y); wr(7, c);
    endtask

    task automatic set_alarm(input logic [7:0] s, m, h, d, mo, y, c);
        wait_upd();
        wr(8, s); wr(9, m); wr(10, h); wr(11, d);
        wr(12, mo); wr(13, y); wr(14, c);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rd_chk("R1 sec", 0, 8'h00);   rd_chk("R1 min", 1, 8'h00);
        rd_chk("R1 hour", 2, 8'h00);  rd_chk("R1 dow", 3, 8'h01);
        rd_chk("R1 date", 4, 8'h01);  rd_chk("R1 month", 5, 8'h01);
        rd_chk("R1 year", 6, 8'h00);  rd_chk("R1 cent", 7, 8'h00);
        rd_chk("R1 alarm sec", 8, 8'h00);
        rd_chk("R1 wake cent", 14, 8'h00);
        chk("R1 upd_done", {7'b0, upd_done}, 8'h00);
        chk("R1 alarm_tod", {7'b0, alarm_tod}, 8'h00);
        chk("R1 alarm_wake", {7'b0, alarm_wake}, 8'h00);
        rst_n = 1'b1;
    endtask

    // R7 R5 R4 R2: full rollover in BCD
    task automatic t_rollover_bcd();
        bin_mode = 1'b0;
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h99);
        wait_upd();
        chk("R8 upd at advance", {7'b0, upd_done}, 8'h01);
        rd_chk("R2 sec wrap", 0, 8'h00);  rd_chk("R2 min wrap", 1, 8'h00);
        rd_chk("R2 hour wrap", 2, 8'h00); rd_chk("R4 dow wrap", 3, 8'h01);
        rd_chk("R5 date wrap", 4, 8'h01); rd_chk("R5 month wrap", 5, 8'h01);
        rd_chk("R7 year wrap", 6, 8'h00); rd_chk("R7 century wrap", 7, 8'h00);
    endtask

    // R3 R2 R8: binary encoding, advance period, strobe width
    task automatic t_binary();
        int n = 0;
        bin_mode = 1'b1;
        set_time(8'h3B, 8'h05, 8'h0A, 8'h02, 8'h0A, 8'h03, 8'h10, 8'h14);
        wait_upd();
        rd_chk("R3 bin sec", 0, 8'h00);
        rd_chk("R3 bin min", 1, 8'h06);
        chk("R8 one cycle", {7'b0, upd_done}, 8'h00);
        do begin
            @(negedge clk);
            n++;
        end while (!upd_done && n < 4 * DIV);
        chk("R2 period", 8'(n + 2), 8'(DIV));
        rd_chk("R3 bin sec step", 0, 8'h01);
        // R13: no change inside the window
        repeat (5) @(negedge clk);
        rd_chk("R13 hold", 0, 8'h01);
    endtask

    task automatic feb_case(input string tag, input logic bm, input logic [7:0] y, c, d,
                            input logic [7:0] mo, input logic [7:0] ed, emo);
        bin_mode = bm;
        set_time(bm ? 8'h3B : 8'h59, bm ? 8'h3B : 8'h59, bm ? 8'h17 : 8'h23,
                 8'h03, d, mo, y, c);
        wait_upd();
        rd_chk({tag, " date"}, 4, ed);
        rd_chk({tag, " month"}, 5, emo);
    endtask

    task automatic t_leap();
        feb_case("R6 2000 leap", 1'b0, 8'h00, 8'h20, 8'h28, 8'h02, 8'h29, 8'h02);
        feb_case("R6 1900 not leap", 1'b0, 8'h00, 8'h19, 8'h28, 8'h02, 8'h01, 8'h03);
        feb_case("R6 2024 leap", 1'b1, 8'h18, 8'h14, 8'h1C, 8'h02, 8'h1D, 8'h02);
        feb_case("R6 2023 not leap", 1'b1, 8'h17, 8'h14, 8'h1C, 8'h02, 8'h01, 8'h03);
        feb_case("R5 april 30", 1'b0, 8'h25, 8'h20, 8'h30, 8'h04, 8'h01, 8'h05);
        feb_case("R5 may 30", 1'b0, 8'h25, 8'h20, 8'h30, 8'h05, 8'h31, 8'h05);
    endtask

    // R9 R10: alarm matching with don't-care fields
    task automatic t_alarms();
        bin_mode = 1'b0;
        set_alarm(8'h05, 8'hC0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00);
        set_time(8'h04, 8'h33, 8'h11, 8'h01, 8'h15, 8'h06, 8'h30, 8'h20);
        wait_upd();
        chk("R9 tod hit", {7'b0, alarm_tod}, 8'h01);
        chk("R10 wake miss date", {7'b0, alarm_wake}, 8'h00);
        wait_upd();
        chk("R9 tod no hit", {7'b0, alarm_tod}, 8'h00);
        set_alarm(8'h07, 8'hC0, 8'hC0, 8'h15, 8'h06, 8'h30, 8'h20);
        set_time(8'h06, 8'h00, 8'h00, 8'h01, 8'h15, 8'h06, 8'h30, 8'h20);
        wait_upd();
        chk("R10 wake hit", {7'b0, alarm_wake}, 8'h01);
        chk("R9 tod with wake", {7'b0, alarm_tod}, 8'h01);
        set_time(8'h06, 8'h00, 8'h00, 8'h01, 8'h15, 8'h06, 8'h30, 8'h21);
        wait_upd();
        chk("R10 wake century miss", {7'b0, alarm_wake}, 8'h00);
        chk("R9 tod still hit", {7'b0, alarm_tod}, 8'h01);
    endtask

    // R12: write lands on the advance edge
    task automatic t_collide();
        bin_mode = 1'b0;
        set_time(8'h10, 8'h20, 8'h08, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
        wait_upd();
        repeat (DIV - 1) @(negedge clk);
        wr(1, 8'h45);
        chk("R12 upd after collide", {7'b0, upd_done}, 8'h01);
        rd_chk("R12 sec advanced", 0, 8'h12);
        rd_chk("R12 min written", 1, 8'h45);
        rd_chk("R12 hour kept", 2, 8'h08);
    endtask

    // R11: register readback and unused address
    task automatic t_regs();
        set_alarm(8'h12, 8'h34, 8'h56, 8'h01, 8'h02, 8'h03, 8'h04);
        rd_chk("R11 alarm min", 9, 8'h34);
        rd_chk("R11 wake year", 13, 8'h03);
        rd_chk("R11 addr 15", 15, 8'h00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_rollover_bcd();
        t_binary();
        t_leap();
        t_alarms();
        t_collide();
        t_regs();
        summary();
        $finish;
    end

endmodule